// File: doc/BRIEF.md
# Cascadable Fixed-Priority Request Encoder

The block turns a word of request lines into the binary index of the most important active request. Higher index means higher priority. Each 8-line encoding slice has an enable input. It also has two status flags. The first, "group active", says that some request in the slice is being served. The second, "enable out", says that the slice is enabled and has nothing to serve. With these flags, a request on line 0 can be told apart from no request at all, even though both give code zero.

The top chains two slices into a 16-line encoder. The upper slice receives the external enable. Its "enable out" drives the enable of the lower slice, so the lower slice only reports when no upper line is active. The code MSB is the upper slice's group-active flag. The low code bits are the OR of both slice codes. The three outputs are registered, so a request pattern shows up on the outputs one clock after it is sampled. Reset is synchronous and active high.

Top module: `prio_enc_cascade`

## Requirements
- R1: One cycle after sampling, `code` holds the index of the highest-numbered active request line, with lower active lines ignored. Line 15 active always gives code 15 (4'b1111).
- R2: When exactly one request line is active, `code` equals the binary number of that line.
- R3: When `en_in` is 0, the request lines have no effect: on the next cycle `code` is 0, `grp_act` is 0 and `en_out` is 0.
- R4: `grp_act` is 1 on the cycle after `en_in` is 1 with at least one request active, and 0 otherwise.
- R5: `en_out` is 1 on the cycle after `en_in` is 1 with no request active, and 0 otherwise. `grp_act` and `en_out` are never both 1.
- R6: Line 0 alone gives code 0 with `grp_act`=1 and `en_out`=0. No request gives code 0 with `grp_act`=0 and `en_out`=1.
- R7: `code[3]` is 1 exactly when an enabled request in the upper half (lines 15..8) is active. In that case the lower half has no effect on `code`.
- R8: While `rst` is high at a clock edge, all outputs become 0 on that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Encoder enable |
| req | input | 16 | Request lines, bit 15 highest priority |
| code | output | 4 | Registered index of the winning line |
| grp_act | output | 1 | Registered: some enabled request is active |
| en_out | output | 1 | Registered: enabled and no request active |

## Verification
The properties assume that `en_in` and `req` are stable around each rising edge, so that the registered outputs depend only on the pattern sampled at the preceding edge. The stimulus meets this by changing inputs only on falling edges. It sweeps every lower-half pattern and every upper-half pattern with both enable values, and then adds pseudo-random full-width patterns. A behavioural highest-set-bit model predicts the outputs and is compared on every cycle.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  localparam int unsigned DEF_SEG_REQ = 8;

  typedef struct packed {
    logic busy;
    logic idle;
  } pe_flags_t;
endpackage

// File: rtl/pe_slice.sv
`timescale 1ns/1ps
module pe_slice
  import pe_pkg::*;
#(
  parameter int unsigned NREQ = DEF_SEG_REQ,
  localparam int unsigned CW  = $clog2(NREQ)
) (
  input  logic            en,
  input  logic [NREQ-1:0] lines,
  output logic [CW-1:0]   idx,
  output pe_flags_t       flags
);
  logic [CW-1:0] win;
  logic          seen;

  always_comb begin
    win  = '0;
    seen = 1'b0;
    for (int i = 0; i < int'(NREQ); i++) begin
      if (lines[i]) begin
        win  = CW'(i);
        seen = 1'b1;
      end
    end
  end

  assign idx        = en ? win : '0;
  assign flags.busy = en & seen;
  assign flags.idle = en & ~seen;
endmodule

// File: rtl/pe_merge.sv
`timescale 1ns/1ps
module pe_merge
  import pe_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic [CW-1:0] up_idx,
  input  pe_flags_t     up_flags,
  input  logic [CW-1:0] dn_idx,
  input  pe_flags_t     dn_flags,
  output logic [CW:0]   idx,
  output logic          busy,
  output logic          idle
);
  assign idx  = {up_flags.busy, up_idx | dn_idx};
  assign busy = up_flags.busy | dn_flags.busy;
  assign idle = dn_flags.idle;
endmodule

// File: rtl/prio_enc_cascade.sv
`timescale 1ns/1ps
module prio_enc_cascade
  import pe_pkg::*;
#(
  parameter int unsigned SEG_REQ = DEF_SEG_REQ,
  localparam int unsigned SEGS   = 2,
  localparam int unsigned TOT    = SEGS * SEG_REQ,
  localparam int unsigned SCW    = $clog2(SEG_REQ),
  localparam int unsigned CW     = SCW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en_in,
  input  logic [TOT-1:0] req,
  output logic [CW-1:0]  code,
  output logic           grp_act,
  output logic           en_out
);
  logic      [SEGS-1:0] seg_en;
  logic      [SCW-1:0]  seg_idx [SEGS];
  pe_flags_t            seg_fl  [SEGS];

  genvar g;
  generate
    for (g = 0; g < int'(SEGS); g++) begin : g_seg
      if (g == int'(SEGS) - 1) begin : g_top
        assign seg_en[g] = en_in;
      end else begin : g_chain
        assign seg_en[g] = seg_fl[g+1].idle;
      end
      pe_slice #(.NREQ(SEG_REQ)) u_slice (
        .en    (seg_en[g]),
        .lines (req[g*SEG_REQ +: SEG_REQ]),
        .idx   (seg_idx[g]),
        .flags (seg_fl[g])
      );
    end
  endgenerate

  logic [CW-1:0] nx_code;
  logic          nx_busy;
  logic          nx_idle;

  pe_merge #(.CW(SCW)) u_merge (
    .up_idx   (seg_idx[1]),
    .up_flags (seg_fl[1]),
    .dn_idx   (seg_idx[0]),
    .dn_flags (seg_fl[0]),
    .idx      (nx_code),
    .busy     (nx_busy),
    .idle     (nx_idle)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code    <= '0;
      grp_act <= 1'b0;
      en_out  <= 1'b0;
    end else begin
      code    <= nx_code;
      grp_act <= nx_busy;
      en_out  <= nx_idle;
    end
  end
endmodule

// File: rtl/prio_enc_cascade_chk.sv
`timescale 1ns/1ps
module prio_enc_cascade_chk #(
  parameter int unsigned TOT = 16,
  parameter int unsigned CW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en_in,
  input logic [TOT-1:0] req,
  input logic [CW-1:0]  code,
  input logic           grp_act,
  input logic           en_out
);
  localparam int unsigned HALF = TOT / 2;

  AST_TOP_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (en_in && req[TOT-1]) |=> (code == CW'(TOT-1))); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en_in |=> (code == '0 && !grp_act && !en_out)); // R3
  AST_BUSY_SET: assert property (@(posedge clk) disable iff (rst)
    (en_in && (req != '0)) |=> grp_act); // R4
  AST_IDLE_SET: assert property (@(posedge clk) disable iff (rst)
    (en_in && (req == '0)) |=> (en_out && code == '0)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grp_act && en_out)); // R5
  AST_ZERO_LINE: assert property (@(posedge clk) disable iff (rst)
    (en_in && req == TOT'(1)) |=> (code == '0 && grp_act && !en_out)); // R6
  AST_UPPER_MSB: assert property (@(posedge clk) disable iff (rst)
    (en_in && (req[TOT-1:HALF] != '0)) |=> code[CW-1]); // R7
  AST_LOWER_NO_MSB: assert property (@(posedge clk) disable iff (rst)
    (req[TOT-1:HALF] == '0) |=> !code[CW-1]); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code == '0 && !grp_act && !en_out)); // R8
endmodule

bind prio_enc_cascade prio_enc_cascade_chk #(.TOT(TOT), .CW(CW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en_in   (en_in),
  .req     (req),
  .code    (code),
  .grp_act (grp_act),
  .en_out  (en_out)
);

// File: tb/prio_enc_cascade_tb.sv
`timescale 1ns/1ps
module prio_enc_cascade_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_in = 1'b0;
  logic [15:0] req = '0;
  logic [3:0]  code;
  logic        grp_act;
  logic        en_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  prio_enc_cascade u_dut (
    .clk(clk), .rst(rst), .en_in(en_in), .req(req),
    .code(code), .grp_act(grp_act), .en_out(en_out)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic compare(string tag, logic [3:0] ec, logic eg, logic eo);
    total++;
    if (code !== ec || grp_act !== eg || en_out !== eo) begin
      bad++;
      $display("FAIL %s: got code=%0d grp=%0b eo=%0b, expected code=%0d grp=%0b eo=%0b",
               tag, code, grp_act, en_out, ec, eg, eo);
    end
  endtask

  // Behavioural reference: highest set bit wins, gated by the enable.
  task automatic step(string tag, logic e, logic [15:0] r);
    int hi;
    logic [3:0] ec;
    logic eg, eo;
    en_in = e;
    req   = r;
    hi = -1;
    for (int i = 0; i < 16; i++) if (r[i]) hi = i;
    if (!e) begin
      ec = 0; eg = 0; eo = 0;
    end else if (hi < 0) begin
      ec = 0; eg = 0; eo = 1;
    end else begin
      ec = 4'(hi); eg = 1; eo = 0;
    end
    @(negedge clk);
    compare(tag, ec, eg, eo);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    @(negedge clk);
    en_in = 1'b1;
    req   = 16'hFFFF;
    @(negedge clk);
    compare("R8 reset with active inputs", 4'd0, 1'b0, 1'b0);
    @(negedge clk);
    compare("R8 reset held", 4'd0, 1'b0, 1'b0);
    rst = 1'b0;

    step("R6 no request", 1'b1, 16'h0000);
    step("R6 line 0 alone", 1'b1, 16'h0001);
    step("R1 line 15 with all", 1'b1, 16'hFFFF);
    for (int i = 0; i < 16; i++) step("R2 single line", 1'b1, 16'(1) << i);
    for (int p = 0; p < 256; p++) step("R1 lower half sweep", 1'b1, 16'(p));
    for (int p = 0; p < 256; p++) step("R7 upper half sweep", 1'b1, {8'(p), 8'(255 - p)});
    for (int p = 0; p < 256; p++) step("R3 disabled sweep", 1'b0, {8'(p), 8'(p)});
    step("R4 busy after idle", 1'b1, 16'h0000);
    step("R4 busy", 1'b1, 16'h0100);
    step("R5 idle after busy", 1'b1, 16'h0000);
    step("R3 disable drops flags", 1'b0, 16'h0000);

    lfsr = 32'hACE1_1234;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R1 random", (k % 7) != 0, lfsr[15:0] & (k[1] ? lfsr[31:16] : 16'hFFFF));
    end

    rst = 1'b1;
    en_in = 1'b1;
    req = 16'h8001;
    @(negedge clk);
    compare("R8 reset mid-run", 4'd0, 1'b0, 1'b0);
    finish_run();
  end
endmodule